// File: doc/BRIEF.md
# Jump Target Instruction Pointer Update Unit

This block works out the next instruction pointer for control transfers that stay inside the current code segment. For each fetched instruction it receives the instruction's start address, its byte length, a transfer mode, a take flag from the condition logic, and the possible target sources. These sources are the operand bytes in fetch order, a register value and a memory-read value. It produces the next pointer combinationally, and it loads that value into an internal pointer register on a clock edge when the update strobe is high.

An ordinary instruction only advances the pointer by its length. A relative transfer adds a signed offset to the advanced pointer, not to the address of the opcode. An absolute transfer replaces the pointer with the operand constant. The two indirect modes replace it with the register value or the memory value. The operand bytes are given in the order they were fetched, and the first byte is the least significant one. All pointer arithmetic wraps at the pointer width.

Top module: `ipnext_unit`

## Requirements
- R1: When `rst` is high at a clock edge, `ip_q` takes `RESET_VEC` (0xFFF0 by default) on that edge, even if `upd_en` is also high.
- R2: With `mode` = 0 (sequential), `next_ip` equals `cur_ip + ilen` modulo 2^16, whatever the value of `take`.
- R3: With `mode` = 1 (relative) and `take` high, `next_ip` equals `cur_ip + ilen + ofs` modulo 2^16. Here `ofs` is the two's-complement value whose low byte is `op_stream[15:8]` (the first fetched byte) and whose high byte is `op_stream[7:0]`. For example, cur 0x0034, length 3 and stream 0x1002 give 0x0247.
- R4: With `mode` = 2 (absolute) and `take` high, `next_ip` equals the operand value assembled as in R3, for example stream 0x1002 gives 0x0210.
- R5: With `mode` = 3 (register indirect) and `take` high, `next_ip` equals `reg_val`.
- R6: With `mode` = 4 (memory indirect) and `take` high, `next_ip` equals `mem_val`.
- R7: With `take` low, `next_ip` equals `cur_ip + ilen` modulo 2^16 in every mode.
- R8: Mode codes 5, 6 and 7 are reserved and behave like mode 0.
- R9: When `rst` is low and `upd_en` is high at a clock edge, `ip_q` takes the `next_ip` value present before that edge.
- R10: When `rst` and `upd_en` are both low at a clock edge, `ip_q` keeps its value.
- R11: A negative relative offset moves the pointer backward, and sums past 0xFFFF or below 0 wrap around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Load `next_ip` into `ip_q` on this edge |
| cur_ip | input | 16 | Address of the fetched instruction |
| ilen | input | 3 | Instruction length in bytes |
| mode | input | 3 | 0 seq, 1 relative, 2 absolute, 3 register, 4 memory, 5-7 reserved |
| take | input | 1 | Transfer taken |
| op_stream | input | 16 | Operand bytes in fetch order, first byte in bits 15:8 |
| reg_val | input | 16 | Register-indirect target |
| mem_val | input | 16 | Memory-indirect target |
| next_ip | output | 16 | Combinational next pointer |
| ip_q | output | 16 | Registered pointer |

## Verification
Two functions can act in the same cycle: the pointer load from `next_ip` and the reset load. The bench raises `rst` while `upd_en` is high and a taken transfer is selecting a target other than the reset vector, then checks that `ip_q` holds `RESET_VEC`. A second overlap is the advance by the instruction length and the addition of the relative offset, which share one sum. The sweep places `cur_ip` near 0xFFFF with positive offsets and low with negative offsets, and each result is compared with a value the bench computes modulo 2^16.

// File: rtl/ipnext_pkg.sv
package ipnext_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      JM_SEQ = 3'd0,
      JM_REL = 3'd1,
      JM_ABS = 3'd2,
      JM_REG = 3'd3,
      JM_MEM = 3'd4
   } jmode_e;
endpackage

// File: rtl/ipnext_lane_swap.sv
// Reorders operand bytes from fetch order (first byte in top lane) into a value
// whose first byte is least significant.
module ipnext_lane_swap #(
   parameter int IP_W = 16
) (
   input  logic [IP_W-1:0] stream,
   output logic [IP_W-1:0] value
);
   localparam int LANES = IP_W / 8;

   generate
      if ((IP_W % 8) != 0 || IP_W < 8) begin : g_bad_width
         $error("ipnext_lane_swap: IP_W must be a positive multiple of 8");
      end
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign value[8*k +: 8] = stream[8*(LANES-1-k) +: 8];
      end
   endgenerate
endmodule

// File: rtl/ipnext_fallthru.sv
// Pointer after the whole instruction has been fetched.
module ipnext_fallthru #(
   parameter int IP_W  = 16,
   parameter int LEN_W = 3
) (
   input  logic [IP_W-1:0]  cur_ip,
   input  logic [LEN_W-1:0] ilen,
   output logic [IP_W-1:0]  post_ip
);
   generate
      if (LEN_W < 1 || LEN_W >= IP_W) begin : g_bad_len
         $error("ipnext_fallthru: LEN_W must lie in 1..IP_W-1");
      end
   endgenerate

   logic [IP_W-1:0] len_ext;
   assign len_ext = {{(IP_W-LEN_W){1'b0}}, ilen};
   assign post_ip = cur_ip + len_ext;
endmodule

// File: rtl/ipnext_select.sv
// Chooses the next pointer from the fall-through value and the target sources.
module ipnext_select
   import ipnext_pkg::*;
#(
   parameter int IP_W = 16
) (
   input  logic [MODE_W-1:0] mode,
   input  logic              take,
   input  logic [IP_W-1:0]   post_ip,
   input  logic [IP_W-1:0]   operand,
   input  logic [IP_W-1:0]   reg_val,
   input  logic [IP_W-1:0]   mem_val,
   output logic [IP_W-1:0]   next_ip
);
   logic [IP_W-1:0] rel_ip;

   // Two's-complement addition wraps at IP_W, which also covers negative offsets.
   assign rel_ip = post_ip + operand;

   always_comb begin
      next_ip = post_ip;
      if (take) begin
         case (mode)
            JM_REL:  next_ip = rel_ip;
            JM_ABS:  next_ip = operand;
            JM_REG:  next_ip = reg_val;
            JM_MEM:  next_ip = mem_val;
            default: next_ip = post_ip;
         endcase
      end
   end
endmodule

// File: rtl/ipnext_unit.sv
module ipnext_unit
   import ipnext_pkg::*;
#(
   parameter int              IP_W      = 16,
   parameter int              LEN_W     = 3,
   parameter logic [IP_W-1:0] RESET_VEC = 16'hFFF0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_en,
   input  logic [IP_W-1:0]   cur_ip,
   input  logic [LEN_W-1:0]  ilen,
   input  logic [MODE_W-1:0] mode,
   input  logic              take,
   input  logic [IP_W-1:0]   op_stream,
   input  logic [IP_W-1:0]   reg_val,
   input  logic [IP_W-1:0]   mem_val,
   output logic [IP_W-1:0]   next_ip,
   output logic [IP_W-1:0]   ip_q
);
   logic [IP_W-1:0] post_ip;
   logic [IP_W-1:0] operand;

   ipnext_fallthru #(.IP_W(IP_W), .LEN_W(LEN_W)) fall_i (
      .cur_ip (cur_ip),
      .ilen   (ilen),
      .post_ip(post_ip)
   );

   ipnext_lane_swap #(.IP_W(IP_W)) swap_i (
      .stream(op_stream),
      .value (operand)
   );

   ipnext_select #(.IP_W(IP_W)) sel_i (
      .mode   (mode),
      .take   (take),
      .post_ip(post_ip),
      .operand(operand),
      .reg_val(reg_val),
      .mem_val(mem_val),
      .next_ip(next_ip)
   );

   always_ff @(posedge clk) begin
      if (rst)         ip_q <= RESET_VEC;
      else if (upd_en) ip_q <= next_ip;
   end
endmodule

// File: rtl/ipnext_unit_chk.sv
module ipnext_unit_chk
   import ipnext_pkg::*;
#(
   parameter int              IP_W      = 16,
   parameter int              LEN_W     = 3,
   parameter logic [IP_W-1:0] RESET_VEC = 16'hFFF0
) (
   input logic              clk,
   input logic              rst,
   input logic              upd_en,
   input logic [IP_W-1:0]   cur_ip,
   input logic [LEN_W-1:0]  ilen,
   input logic [MODE_W-1:0] mode,
   input logic              take,
   input logic [IP_W-1:0]   reg_val,
   input logic [IP_W-1:0]   mem_val,
   input logic [IP_W-1:0]   next_ip,
   input logic [IP_W-1:0]   ip_q
);
   logic [IP_W-1:0] post_c;
   assign post_c = cur_ip + {{(IP_W-LEN_W){1'b0}}, ilen};

   assert_reset_vec_R1: assert property (@(posedge clk)
      rst |=> ip_q == RESET_VEC);

   assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
      mode == JM_SEQ |-> next_ip == post_c);

   assert_reg_target_R5: assert property (@(posedge clk) disable iff (rst)
      (take && mode == JM_REG) |-> next_ip == reg_val);

   assert_mem_target_R6: assert property (@(posedge clk) disable iff (rst)
      (take && mode == JM_MEM) |-> next_ip == mem_val);

   assert_not_taken_R7: assert property (@(posedge clk) disable iff (rst)
      !take |-> next_ip == post_c);

   assert_reserved_mode_R8: assert property (@(posedge clk) disable iff (rst)
      (mode > JM_MEM) |-> next_ip == post_c);

   assert_load_R9: assert property (@(posedge clk) disable iff (rst)
      upd_en |=> ip_q == $past(next_ip));

   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !upd_en |=> $stable(ip_q));
endmodule

bind ipnext_unit ipnext_unit_chk #(
   .IP_W(IP_W), .LEN_W(LEN_W), .RESET_VEC(RESET_VEC)
) chk_i (
   .clk(clk), .rst(rst), .upd_en(upd_en), .cur_ip(cur_ip), .ilen(ilen),
   .mode(mode), .take(take), .reg_val(reg_val), .mem_val(mem_val),
   .next_ip(next_ip), .ip_q(ip_q)
);

// File: tb/ipnext_unit_tb.sv
`timescale 1ns/1ps
module ipnext_unit_tb_top;
   localparam logic [15:0] RVEC = 16'hFFF0;

   logic        clk = 1'b0;
   logic        rst;
   logic        upd_en;
   logic [15:0] cur_ip;
   logic [2:0]  ilen;
   logic [2:0]  mode;
   logic        take;
   logic [15:0] op_stream;
   logic [15:0] reg_val;
   logic [15:0] mem_val;
   logic [15:0] next_ip;
   logic [15:0] ip_q;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ipnext_unit dut_i (
      .clk(clk), .rst(rst), .upd_en(upd_en), .cur_ip(cur_ip), .ilen(ilen),
      .mode(mode), .take(take), .op_stream(op_stream), .reg_val(reg_val),
      .mem_val(mem_val), .next_ip(next_ip), .ip_q(ip_q)
   );

   function automatic logic [15:0] model(input logic [15:0] c, input logic [2:0] l,
                                         input logic [2:0] m, input logic t,
                                         input logic [15:0] s, input logic [15:0] r,
                                         input logic [15:0] mv);
      logic [15:0] post;
      logic [15:0] v;
      post = c + {13'd0, l};
      v    = {s[7:0], s[15:8]};
      if (!t) return post;
      case (m)
         3'd1:    return post + v;
         3'd2:    return v;
         3'd3:    return r;
         3'd4:    return mv;
         default: return post;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] m, input logic t);
      if (m > 3'd4) return "R8";
      if (!t && m != 3'd0) return "R7";
      case (m)
         3'd0:    return "R2";
         3'd1:    return "R3/R11";
         3'd2:    return "R4";
         3'd3:    return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(4.0 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] curs [4];
      logic [15:0] strs [4];
      logic [2:0]  lens [3];
      logic [15:0] exp_q;
      curs = '{16'h0034, 16'h8000, 16'hFFFE, 16'h0002};
      strs = '{16'h1002, 16'hF0FF, 16'hFF7F, 16'h0000};
      lens = '{3'd3, 3'd1, 3'd6};

      rst = 1'b1; upd_en = 1'b0; cur_ip = '0; ilen = '0; mode = '0; take = 1'b0;
      op_stream = '0; reg_val = '0; mem_val = '0;
      @(negedge clk); @(negedge clk);
      check("R1 reset", ip_q, RVEC);
      rst = 1'b0;

      // Worked example: 3-byte relative jump at 0x0034, bytes 10 02.
      cur_ip = 16'h0034; ilen = 3'd3; mode = 3'd1; take = 1'b1; op_stream = 16'h1002;
      upd_en = 1'b1;
      #1 check("R3 example", next_ip, 16'h0247);
      @(negedge clk);
      check("R9 example load", ip_q, 16'h0247);
      mode = 3'd2;
      #1 check("R4 example", next_ip, 16'h0210);
      mode = 3'd0;
      #1 check("R2 example", next_ip, 16'h0037);

      // Sweep.
      for (int ci = 0; ci < 4; ci++)
         for (int si = 0; si < 4; si++)
            for (int li = 0; li < 3; li++)
               for (int mi = 0; mi < 8; mi++)
                  for (int ti = 0; ti < 2; ti++) begin
                     cur_ip = curs[ci]; op_stream = strs[si]; ilen = lens[li];
                     mode = 3'(mi); take = ti[0];
                     reg_val = curs[ci] ^ 16'h5A5A; mem_val = ~curs[ci];
                     upd_en = 1'b1;
                     exp_q = model(cur_ip, ilen, mode, take, op_stream, reg_val, mem_val);
                     #1 check(tag_of(mode, take), next_ip, exp_q);
                     @(negedge clk);
                     check("R9 load", ip_q, exp_q);
                  end

      // Hold with upd_en low while inputs move.
      exp_q = ip_q;
      upd_en = 1'b0;
      for (int k = 0; k < 4; k++) begin
         cur_ip = curs[k]; mode = 3'd2; take = 1'b1; op_stream = strs[k];
         @(negedge clk);
         check("R10 hold", ip_q, exp_q);
      end

      // Reset and update in the same cycle: reset wins.
      cur_ip = 16'h1234; mode = 3'd3; take = 1'b1; reg_val = 16'h4321; upd_en = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset over update", ip_q, RVEC);
      rst = 1'b0;
      @(negedge clk);
      check("R9 after reset", ip_q, 16'h4321);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule